// File: doc/BRIEF.md
# Virtual System Mask Assist

This block lets a hypervisor accelerate three privileged mask instructions issued by a guest running in problem state. The three are: load a new system mask from storage, OR an immediate into the mask while saving the old one, and AND an immediate into the mask while saving the old one. The guest's program status word is kept in memory rather than in the processor. The block walks a control block in that memory to find the virtual status word, tests whether the change is safe, and either rewrites the top byte of that word or reports that the instruction must be given to the hypervisor's slow path.

The processor pulses `start` with the operation kind, the immediate byte, the operand byte address, the control-block base and the state of the "check the assist-control word" gate. The block then makes a sequence of word and byte accesses through a single request/acknowledge memory port. It ends with exactly one pulse, either `donePulse` or `fallbackPulse`. Storage is written only when the assist is going to succeed. A fallback therefore leaves the virtual status word intact, and leaves the operand byte intact unless the later status-word write fails.

Top module: `vsm_assist`

## Requirements
- R1: After reset, and whenever no operation is in progress, the block raises no memory request and neither outcome pulse.
- R2: When `gateCheck` is high at start, the block reads the control-block word at base+20. If bit 23 (0x00800000) of that word is clear, the operation falls back with no memory write.
- R3: The word at base+4 holds, in its low address bits, a pointer to the virtual control register 0. If bit 30 (0x40000000) of that register is set, the load form and the OR form fall back. The AND form ignores that bit.
- R4: The word at base+8 holds, in its low address bits, a pointer to the virtual status word. Its bit 31 is the pending-interrupt flag. Bit 19 of the virtual status word selects extended-control mode.
- R5: Load form (opKind 0) takes the new mask from the byte at the operand address. In extended-control mode it falls back if the new mask has any bit of 0xB8 set, or differs from the old mask in 0x44, or (while pending) turns on a bit of 0x03.
- R6: Load form in basic-control mode falls back only if an interrupt is pending and the new mask turns on any bit that was off.
- R7: OR form (opKind 1) computes old OR immediate. In extended-control mode it falls back if this changes any bit of 0xFC, or turns on a bit of 0x03 while pending. In basic-control mode it falls back if it turns on any bit while pending.
- R8: AND form (opKind 2) computes old AND immediate. In extended-control mode it falls back unless both bits of 0x44 are set in the immediate.
- R9: The OR and AND forms write the old mask byte to the operand address before the status word is updated. If that write reports an error, the operation falls back and the status word is unchanged.
- R10: On success the virtual status word is rewritten with the new mask in bits 31:24 and its bits 23:0 unchanged, after which `donePulse` follows. Each start yields exactly one of `donePulse` or `fallbackPulse`.
- R11: opKind 3 is reserved; it falls back with no memory write.
- R12: While a request is waiting for its acknowledge, the address, the write flag and the request stay unchanged.
- R13: A read error on the load-form operand fetch, or on any control-block read, makes the operation fall back with no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| opKind | input | 2 | 0 load mask, 1 OR immediate, 2 AND immediate, 3 reserved |
| immByte | input | 8 | Immediate byte for the OR and AND forms |
| operandAddr | input | AW | Byte address of the operand |
| ctlBase | input | AW | Byte address of the control block (word aligned) |
| gateCheck | input | 1 | Require the assist-control word bit before running |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memByte | output | 1 | Request is a single byte (data in bits 7:0) |
| memAddr | output | AW | Byte address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with the acknowledge |
| memAck | input | 1 | Access complete |
| memErr | input | 1 | Access failed (valid with the acknowledge) |
| donePulse | output | 1 | Assist completed, status word updated |
| fallbackPulse | output | 1 | Assist declined; slow path must run |

## Verification
The assertions check, on every cycle, the protocol properties that hold for any data. These are: a single outcome at a time, requests held steady until acknowledged, a success pulse only straight after a status-word write, byte writes only for the OR and AND forms, no writes for the reserved kind, and a fallback after any memory error. Whether a given combination of old mask, new mask, control mode and pending flag is accepted, and which byte is stored, can only be shown by the bench. It sweeps every form in both control modes, with and without a pending interrupt, over a grid of old and new masks. It then drives the gate, the control-register block bit and error injection on the operand access.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

  localparam int DW = 32;
  localparam int MASK_W = 8;

  // control-block word offsets (in words)
  localparam int OFS_VCR_PTR = 1;
  localparam int OFS_PSW_PTR = 2;
  localparam int OFS_ACF     = 5;

  // bit positions
  localparam int ACF_ENABLE_BIT = 23;
  localparam int VCR_BLOCK_BIT  = 30;
  localparam int PEND_BIT       = 31;
  localparam int EC_MODE_BIT    = 19;

  // mask groups
  localparam logic [MASK_W-1:0] EC_RESERVED = 8'hB8;
  localparam logic [MASK_W-1:0] XLATE_PER   = 8'h44;
  localparam logic [MASK_W-1:0] IO_EXT      = 8'h03;
  localparam logic [MASK_W-1:0] OR_FROZEN   = 8'hFC;

  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_OR   = 2'd1,
    OP_AND  = 2'd2,
    OP_RSVD = 2'd3
  } opKind_e;

  typedef enum logic [2:0] {
    SEL_ACF, SEL_VCRP, SEL_VCR, SEL_PSWP, SEL_PSW, SEL_OPND
  } addrSel_e;

  typedef struct packed {
    logic     load;
    logic     capAcf;
    logic     capVcrPtr;
    logic     capVcr;
    logic     capPswPtr;
    logic     capPsw;
    logic     capOpnd;
    logic     wrPsw;
    addrSel_e sel;
  } dpCtl_t;

endpackage

// File: rtl/vsm_dp.sv
module vsm_dp
  import vsm_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  opKind_e           opIn,
  input  logic [MASK_W-1:0] immIn,
  input  logic [AW-1:0]     opndIn,
  input  logic [AW-1:0]     baseIn,
  input  logic              gateIn,
  input  logic [DW-1:0]     memRdata,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata,
  output logic              reject,
  output logic              opIsSet
);

  localparam int MASK_LSB = DW - MASK_W;

  opKind_e           opQ;
  logic [MASK_W-1:0] immQ;
  logic [AW-1:0]     opndQ;
  logic [AW-1:0]     baseQ;
  logic              gateQ;
  logic              acfOkQ;
  logic [AW-1:0]     vcrPtrQ;
  logic              vcrBlockQ;
  logic [AW-1:0]     pswPtrQ;
  logic              pendQ;
  logic [DW-1:0]     pswQ;
  logic [MASK_W-1:0] fetchedQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opQ       <= OP_SET;
      immQ      <= '0;
      opndQ     <= '0;
      baseQ     <= '0;
      gateQ     <= 1'b0;
      acfOkQ    <= 1'b0;
      vcrPtrQ   <= '0;
      vcrBlockQ <= 1'b0;
      pswPtrQ   <= '0;
      pendQ     <= 1'b0;
      pswQ      <= '0;
      fetchedQ  <= '0;
    end else begin
      if (ctl.load) begin
        opQ       <= opIn;
        immQ      <= immIn;
        opndQ     <= opndIn;
        baseQ     <= baseIn;
        gateQ     <= gateIn;
        acfOkQ    <= 1'b0;
        vcrBlockQ <= 1'b0;
      end
      if (ctl.capAcf)    acfOkQ    <= memRdata[ACF_ENABLE_BIT];
      if (ctl.capVcrPtr) vcrPtrQ   <= memRdata[AW-1:0];
      if (ctl.capVcr)    vcrBlockQ <= memRdata[VCR_BLOCK_BIT];
      if (ctl.capPswPtr) begin
        pswPtrQ <= memRdata[AW-1:0];
        pendQ   <= memRdata[PEND_BIT];
      end
      if (ctl.capPsw)    pswQ      <= memRdata;
      if (ctl.capOpnd)   fetchedQ  <= memRdata[MASK_W-1:0];
    end
  end

  // address selection
  always_comb begin
    unique case (ctl.sel)
      SEL_ACF:  memAddr = baseQ + AW'(OFS_ACF * 4);
      SEL_VCRP: memAddr = baseQ + AW'(OFS_VCR_PTR * 4);
      SEL_VCR:  memAddr = vcrPtrQ;
      SEL_PSWP: memAddr = baseQ + AW'(OFS_PSW_PTR * 4);
      SEL_PSW:  memAddr = pswPtrQ;
      SEL_OPND: memAddr = opndQ;
      default:  memAddr = baseQ;
    endcase
  end

  // mask evaluation
  logic [MASK_W-1:0] oldMask;
  logic [MASK_W-1:0] newMask;
  logic [MASK_W-1:0] risen;
  logic [MASK_W-1:0] changed;
  logic              ecMode;
  logic              modeReject;

  assign oldMask = pswQ[DW-1:MASK_LSB];
  assign ecMode  = pswQ[EC_MODE_BIT];

  always_comb begin
    unique case (opQ)
      OP_SET:  newMask = fetchedQ;
      OP_OR:   newMask = oldMask | immQ;
      OP_AND:  newMask = oldMask & immQ;
      default: newMask = oldMask;
    endcase
  end

  assign risen   = newMask & ~oldMask;
  assign changed = newMask ^ oldMask;

  always_comb begin
    modeReject = 1'b0;
    unique case (opQ)
      OP_SET: begin
        if (ecMode)
          modeReject = (|(newMask & EC_RESERVED)) || (|(changed & XLATE_PER)) ||
                       (pendQ && (|(risen & IO_EXT)));
        else
          modeReject = pendQ && (|risen);
      end
      OP_OR: begin
        if (ecMode)
          modeReject = (|(changed & OR_FROZEN)) || (pendQ && (|(risen & IO_EXT)));
        else
          modeReject = pendQ && (|risen);
      end
      OP_AND:  modeReject = ecMode && ((immQ & XLATE_PER) != XLATE_PER);
      default: modeReject = 1'b1;
    endcase
  end

  assign reject = (gateQ && !acfOkQ) || (vcrBlockQ && (opQ != OP_AND)) || modeReject;
  assign opIsSet = (opQ == OP_SET);

  assign memWdata = ctl.wrPsw ? {newMask, pswQ[MASK_LSB-1:0]}
                              : {{(DW-MASK_W){1'b0}}, oldMask};

endmodule

// File: rtl/vsm_ctrl.sv
module vsm_ctrl
  import vsm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   gateCheck,
  input  logic   memAck,
  input  logic   memErr,
  input  logic   reject,
  input  logic   opIsSet,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   memWe,
  output logic   memByte,
  output logic   donePulse,
  output logic   fallbackPulse
);

  typedef enum logic [3:0] {
    S_IDLE, S_ACF, S_VCRP, S_VCR, S_PSWP, S_PSW, S_OPND,
    S_CHECK, S_WROLD, S_WRPSW, S_DONE, S_FAIL
  } state_e;

  state_e st, nxt;
  logic   okAck;

  assign okAck = memAck && !memErr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt = st;
    ctl = '0;
    ctl.sel = SEL_ACF;
    unique case (st)
      S_IDLE: if (start) begin
        ctl.load = 1'b1;
        nxt = gateCheck ? S_ACF : S_VCRP;
      end
      S_ACF: begin
        ctl.sel = SEL_ACF;
        ctl.capAcf = okAck;
        if (memAck) nxt = memErr ? S_FAIL : S_VCRP;
      end
      S_VCRP: begin
        ctl.sel = SEL_VCRP;
        ctl.capVcrPtr = okAck;
        if (memAck) nxt = memErr ? S_FAIL : S_VCR;
      end
      S_VCR: begin
        ctl.sel = SEL_VCR;
        ctl.capVcr = okAck;
        if (memAck) nxt = memErr ? S_FAIL : S_PSWP;
      end
      S_PSWP: begin
        ctl.sel = SEL_PSWP;
        ctl.capPswPtr = okAck;
        if (memAck) nxt = memErr ? S_FAIL : S_PSW;
      end
      S_PSW: begin
        ctl.sel = SEL_PSW;
        ctl.capPsw = okAck;
        if (memAck) nxt = memErr ? S_FAIL : (opIsSet ? S_OPND : S_CHECK);
      end
      S_OPND: begin
        ctl.sel = SEL_OPND;
        ctl.capOpnd = okAck;
        if (memAck) nxt = memErr ? S_FAIL : S_CHECK;
      end
      S_CHECK: nxt = reject ? S_FAIL : (opIsSet ? S_WRPSW : S_WROLD);
      S_WROLD: begin
        ctl.sel = SEL_OPND;
        if (memAck) nxt = memErr ? S_FAIL : S_WRPSW;
      end
      S_WRPSW: begin
        ctl.sel = SEL_PSW;
        ctl.wrPsw = 1'b1;
        if (memAck) nxt = memErr ? S_FAIL : S_DONE;
      end
      S_DONE:  nxt = S_IDLE;
      S_FAIL:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    memReq = 1'b0;
    unique case (st)
      S_ACF, S_VCRP, S_VCR, S_PSWP, S_PSW, S_OPND, S_WROLD, S_WRPSW: memReq = 1'b1;
      default: memReq = 1'b0;
    endcase
  end

  assign memWe         = (st == S_WROLD) || (st == S_WRPSW);
  assign memByte       = (st == S_OPND) || (st == S_WROLD);
  assign donePulse     = (st == S_DONE);
  assign fallbackPulse = (st == S_FAIL);

endmodule

// File: rtl/vsm_assist.sv
module vsm_assist
  import vsm_pkg::*;
#(
  parameter int AW = 24  // address width, at most 24 (pointer field width)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    opKind,
  input  logic [7:0]    immByte,
  input  logic [AW-1:0] operandAddr,
  input  logic [AW-1:0] ctlBase,
  input  logic          gateCheck,
  output logic          memReq,
  output logic          memWe,
  output logic          memByte,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memAck,
  input  logic          memErr,
  output logic          donePulse,
  output logic          fallbackPulse
);

  dpCtl_t ctl;
  logic   reject;
  logic   opIsSet;

  vsm_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .gateCheck     (gateCheck),
    .memAck        (memAck),
    .memErr        (memErr),
    .reject        (reject),
    .opIsSet       (opIsSet),
    .ctl           (ctl),
    .memReq        (memReq),
    .memWe         (memWe),
    .memByte       (memByte),
    .donePulse     (donePulse),
    .fallbackPulse (fallbackPulse)
  );

  vsm_dp #(.AW(AW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .opIn     (opKind_e'(opKind)),
    .immIn    (immByte),
    .opndIn   (operandAddr),
    .baseIn   (ctlBase),
    .gateIn   (gateCheck),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .reject   (reject),
    .opIsSet  (opIsSet)
  );

endmodule

// File: rtl/vsm_assist_chk.sv
module vsm_assist_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    opKind,
  input logic          memReq,
  input logic          memWe,
  input logic          memByte,
  input logic [AW-1:0] memAddr,
  input logic          memAck,
  input logic          memErr,
  input logic          donePulse,
  input logic          fallbackPulse
);

  logic       busyT;
  logic [1:0] opT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyT <= 1'b0;
      opT   <= 2'd0;
    end else if (!busyT && start) begin
      busyT <= 1'b1;
      opT   <= opKind;
    end else if (donePulse || fallbackPulse) begin
      busyT <= 1'b0;
    end
  end

  // R1: quiet while no operation is in progress
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busyT |-> (!memReq && !donePulse && !fallbackPulse));

  // R10: at most one outcome at a time
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({donePulse, fallbackPulse}));

  // R10: success only right after an acknowledged status-word write
  p_commit_after_psw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |-> $past(memReq && memAck && !memErr && memWe && !memByte));

  // R12: request held steady until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memByte)));

  // R9: byte writes only for OR and AND forms
  p_byte_write_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe && memByte) |-> (busyT && (opT == 2'd1 || opT == 2'd2)));

  // R11: reserved kind never writes
  p_rsvd_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe) |-> (opT != 2'd3));

  // R13: any memory error leads to fallback
  p_err_fallback_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memAck && memErr) |=> fallbackPulse);

endmodule

bind vsm_assist vsm_assist_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .opKind        (opKind),
  .memReq        (memReq),
  .memWe         (memWe),
  .memByte       (memByte),
  .memAddr       (memAddr),
  .memAck        (memAck),
  .memErr        (memErr),
  .donePulse     (donePulse),
  .fallbackPulse (fallbackPulse)
);

// File: tb/vsm_assist_tb.sv
`timescale 1ns/1ps
module vsm_assist_tb;

  localparam int AW = 24;
  localparam logic [AW-1:0] BASE = 24'h000100;
  localparam logic [AW-1:0] OPND = 24'h000202;
  localparam int PSW_IDX  = 'h1C0 >> 2;
  localparam int OPND_IDX = 'h200 >> 2;
  localparam logic [31:0] OPND_INIT = 32'h11223344;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] opKind = 2'd0;
  logic [7:0] immByte = 8'd0;
  logic [AW-1:0] operandAddr = OPND;
  logic [AW-1:0] ctlBase = BASE;
  logic gateCheck = 1'b0;
  logic memReq, memWe, memByte, donePulse, fallbackPulse;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;
  logic memErr = 1'b0;

  logic [31:0] mem [0:255];
  logic errEn = 1'b0;
  logic [AW-1:0] errAddr = '0;

  int vectors = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vsm_assist #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opKind(opKind), .immByte(immByte),
    .operandAddr(operandAddr), .ctlBase(ctlBase), .gateCheck(gateCheck),
    .memReq(memReq), .memWe(memWe), .memByte(memByte), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .memErr(memErr),
    .donePulse(donePulse), .fallbackPulse(fallbackPulse)
  );

  // memory model: big-endian byte lanes, one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      memAck <= 1'b0;
      memErr <= 1'b0;
    end else begin
      memAck <= 1'b0;
      memErr <= 1'b0;
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        if (errEn && memAddr == errAddr) memErr <= 1'b1;
        else if (memWe) begin
          if (memByte) mem[memAddr[9:2]][(3 - memAddr[1:0]) * 8 +: 8] <= memWdata[7:0];
          else         mem[memAddr[9:2]] <= memWdata;
        end else begin
          memRdata <= memByte ? {24'h0, mem[memAddr[9:2]][(3 - memAddr[1:0]) * 8 +: 8]}
                              : mem[memAddr[9:2]];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] low24(input bit ec);
    return {4'h3, ec, 19'h2A5A5};
  endfunction

  task automatic setupMem(input bit ec, input bit pend, input logic [7:0] old,
                          input bit vcrB, input bit acf, input logic [7:0] opByte);
    mem[(BASE >> 2) + 5] = acf ? 32'h00800000 : 32'hFF7FFFFF;
    mem[(BASE >> 2) + 1] = 32'hA5000180;
    mem['h180 >> 2]      = vcrB ? 32'h40000000 : 32'hBFFFFFFF;
    mem[(BASE >> 2) + 2] = {pend, 7'h3C, 24'h0001C0};
    mem[PSW_IDX]         = {old, low24(ec)};
    mem[OPND_IDX]        = {OPND_INIT[31:16], opByte, OPND_INIT[7:0]};
  endtask

  // returns {fallback, newMask}
  function automatic logic [8:0] refModel(input int op, input bit ec, input bit pend,
      input logic [7:0] old, input logic [7:0] val, input bit vcrB, input bit gate, input bit acf);
    logic [7:0] nm, rise, chg;
    bit fb;
    nm = (op == 0) ? val : (op == 1) ? (old | val) : (old & val);
    rise = nm & ~old;
    chg = nm ^ old;
    fb = 1'b0;
    if (op == 3) fb = 1'b1;
    if (gate && !acf) fb = 1'b1;
    if (vcrB && op != 2) fb = 1'b1;
    case (op)
      0: if (ec) begin
           if ((nm & 8'hB8) != 0 || (chg & 8'h44) != 0 || (pend && (rise & 8'h03) != 0)) fb = 1'b1;
         end else if (pend && rise != 0) fb = 1'b1;
      1: if (ec) begin
           if ((chg & 8'hFC) != 0 || (pend && (rise & 8'h03) != 0)) fb = 1'b1;
         end else if (pend && rise != 0) fb = 1'b1;
      2: if (ec && (val & 8'h44) != 8'h44) fb = 1'b1;
      default: ;
    endcase
    return {fb, nm};
  endfunction

  // one operation; returns 1 if done, 0 if fallback
  task automatic runOp(input int op, input logic [7:0] imm, input bit gate, output bit gotDone);
    int n;
    @(negedge clk);
    start = 1'b1; opKind = op[1:0]; immByte = imm; gateCheck = gate;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!(donePulse || fallbackPulse) && n < 100) begin
      @(negedge clk);
      n++;
    end
    gotDone = donePulse;
    if (!(donePulse ^ fallbackPulse)) check(1'b0, "R10 outcome", {30'd0, donePulse, fallbackPulse}, 32'd1);
    @(negedge clk);
  endtask

  // full scenario with expected values
  task automatic scenario(input string tag, input int op, input bit ec, input bit pend,
      input logic [7:0] old, input logic [7:0] val, input bit vcrB, input bit gate, input bit acf,
      input bit opErr);
    logic [8:0] r;
    bit fb, got;
    logic [31:0] expPsw, expOp;
    setupMem(ec, pend, old, vcrB, acf, (op == 0) ? val : 8'h5E);
    errEn = opErr; errAddr = OPND;
    runOp(op, (op == 0) ? ~val : val, gate, got);
    errEn = 1'b0;
    r = refModel(op, ec, pend, old, val, vcrB, gate, acf);
    fb = r[8] || opErr;
    expPsw = fb ? {old, low24(ec)} : {r[7:0], low24(ec)};
    expOp = {OPND_INIT[31:16], (op == 0) ? val : 8'h5E, OPND_INIT[7:0]};
    if (!fb && op != 0) expOp[15:8] = old;
    check(got == !fb, {tag, " outcome"}, {31'd0, got}, {31'd0, !fb});
    check(mem[PSW_IDX] === expPsw, {tag, " R10 psw"}, mem[PSW_IDX], expPsw);
    check(mem[OPND_IDX] === expOp, {tag, " R9 operand"}, mem[OPND_IDX], expOp);
  endtask

  localparam logic [7:0] PAT [8] = '{8'h00, 8'h03, 8'h44, 8'h07, 8'hFF, 8'h5A, 8'hC4, 8'h01};

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!memReq && !donePulse && !fallbackPulse, "R1 reset idle",
          {29'd0, memReq, donePulse, fallbackPulse}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!memReq && !donePulse && !fallbackPulse, "R1 idle after reset",
          {29'd0, memReq, donePulse, fallbackPulse}, 32'd0);

    // R4 R5 R6 R7 R8 R10: sweep forms, modes, pending, masks
    for (int op = 0; op < 3; op++)
      for (int ec = 0; ec < 2; ec++)
        for (int pd = 0; pd < 2; pd++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
              scenario(op == 0 ? (ec != 0 ? "R5 set-ec" : "R6 set-bc")
                               : op == 1 ? "R7 or" : "R8 and",
                       op, ec[0], pd[0], PAT[i], PAT[j], 1'b0, j[0], 1'b1, 1'b0);

    // R2: gate on, enable bit clear -> fallback; gate off ignores the word
    scenario("R2 gate blocks", 1, 1'b0, 1'b0, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
    scenario("R2 gate off", 1, 1'b0, 1'b0, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
    scenario("R2 gate set", 2, 1'b1, 1'b0, 8'hFF, 8'h44, 1'b0, 1'b1, 1'b1, 1'b0);

    // R3: control register 0 block bit
    scenario("R3 vcr set form", 0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    scenario("R3 vcr or form", 1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    scenario("R3 vcr and form", 2, 1'b0, 1'b0, 8'hFF, 8'h0F, 1'b1, 1'b0, 1'b1, 1'b0);

    // R9: store error on OR and AND forms
    scenario("R9 or store err", 1, 1'b0, 1'b0, 8'h10, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1);
    scenario("R9 and store err", 2, 1'b0, 1'b0, 8'hFF, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b1);

    // R13: operand fetch error on set form
    scenario("R13 fetch err", 0, 1'b0, 1'b0, 8'h00, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1);

    // R11: reserved kind
    scenario("R11 reserved", 3, 1'b0, 1'b0, 8'h12, 8'h34, 1'b0, 1'b0, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule